// File: doc/BRIEF.md
# Byte-Serial Target Port with Flag Handshake

This block is the receiving end of a four-wire serial link. An external controller supplies the bit clock and an active-low select; while selected, the block moves one byte in from the controller's data line and, at the same time, moves a byte that software placed in it back out. Clock idle level and the capture phase can be set to any of the four usual combinations. The clock, select and data pins are taken into the system clock domain through two-flop synchronisers, and the system clock must run at least four times faster than the bit clock.

Software reaches the block over a small register bus with three locations: data, status and control. When a byte finishes, a completion flag is set and the received byte is copied into a separate read buffer. The flag is retired only by reading status while it is up and then reading data. Until that status read, writes to the data location are dropped. A second byte that completes before the flag is retired raises an overrun flag. A data write made while a byte is in flight raises a collision flag.

Top module: `spi_tgt`

## Requirements
- R1: A byte written to the data location (address 0) is sent on `miso` most significant bit first, and the byte arriving on `mosi` is captured most significant bit first. This holds in all four modes set by control bit 0 (clock idle level) and control bit 1 (phase: 0 captures on the first clock edge of a bit, 1 captures on the second).
- R2: Control bits 5:4 are a rate field that reads back but has no effect on transfers.
- R3: On the eighth capture edge, status bit 0 (completion) is set and the received byte is copied into the read buffer; data reads return the buffer, never the partly shifted byte of a transfer in progress.
- R4: `irq` is high exactly when status bit 0 is set and both control bit 2 (interrupt enable) and control bit 3 (interrupt select) are set.
- R5: The status flags clear only when a data read follows a status read made while a flag was set; a data read alone leaves them set.
- R6: While status bit 0 is set and status has not yet been read, data writes are dropped; after the status read they are accepted.
- R7: A completion that arrives while status bit 0 is still set sets status bit 1 (overrun), and the read buffer keeps the earlier byte.
- R8: A data write while a byte is in flight (phase 0: any time select is low) sets status bit 2 (collision) and leaves the byte being sent unchanged.
- R9: Raising select before eight capture edges discards the partial byte: no completion is flagged and the next transfer starts from its first bit.
- R10: After reset all three registers read zero, and `miso` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck | input | 1 | Serial bit clock from the controller |
| ss_n | input | 1 | Active-low select from the controller |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that serial pins change slowly against the system clock, so that each clock edge is seen once through the synchronisers, that bus strobes last one cycle, and that the controller holds select low for a whole byte unless it deliberately aborts. The stimulus drives every pin on the falling system clock edge, holds each half bit for six system cycles, and only raises select mid-byte in the abort case, so every edge reaches the shift logic cleanly and the flag handshake is exercised by distinct, non-overlapping bus accesses.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CTRL = 2'd2
  } addr_e;

  // control layout, low bits first: idle level, phase, enable, select, rate
  typedef struct packed {
    logic [1:0] rate;
    logic       irq_sel;
    logic       irq_en;
    logic       cpha;
    logic       cpol;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // first clock edge of a bit period, given the idle level
  function automatic logic lead_edge(input logic cpol, input logic rise, input logic fall);
    return cpol ? fall : rise;
  endfunction

  // second clock edge of a bit period
  function automatic logic trail_edge(input logic cpol, input logic rise, input logic fall);
    return cpol ? rise : fall;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ss_act,
  input  logic         ss_start,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi_s,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic         miso,
  output logic         busy,
  output logic         done_pulse,
  output logic [W-1:0] rx_next
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  tx_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic          mid_q;

  logic lead_evt, trail_evt, smp_evt, drv_evt;
  assign lead_evt  = ss_act && lead_edge(cpol, sck_rise, sck_fall);
  assign trail_evt = ss_act && trail_edge(cpol, sck_rise, sck_fall);
  assign smp_evt   = cpha ? trail_evt : lead_evt;
  assign drv_evt   = cpha ? lead_evt : (ss_start || trail_evt);

  assign rx_next    = {rx_q[W-2:0], mosi_s};
  assign done_pulse = smp_evt && (cnt_q == LAST);
  assign busy       = ss_act && (!cpha || mid_q || (cnt_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      mid_q <= 1'b0;
      miso  <= 1'b0;
    end else begin
      if (drv_evt) miso <= tx_q[W-1];
      if (load_en)      tx_q <= load_data;
      else if (drv_evt) tx_q <= {tx_q[W-2:0], 1'b0};
      if (!ss_act) begin
        cnt_q <= '0;
        mid_q <= 1'b0;
      end else begin
        if (lead_evt)       mid_q <= 1'b1;
        else if (trail_evt) mid_q <= 1'b0;
        if (smp_evt) begin
          rx_q  <= rx_next;
          cnt_q <= done_pulse ? '0 : cnt_q + 1'b1;
        end
      end
    end
  end

  // deselect always restarts the bit count (R9)
  p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> (cnt_q == '0));

  // a completion only comes from the final capture of a byte (R3)
  p_done_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (cnt_q == '0));
endmodule

// File: rtl/spi_tgt_flags.sv
module spi_tgt_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done_pulse,
  input  logic [W-1:0] rx_next,
  input  logic         stat_rd,
  input  logic         data_rd,
  input  logic         data_wr,
  input  logic         busy,
  input  logic         irq_en,
  input  logic         irq_sel,
  output logic         done,
  output logic         ovr,
  output logic         wcol,
  output logic         armed,
  output logic         wr_ok,
  output logic [W-1:0] rbuf,
  output logic         irq
);
  logic clr_evt, wr_blocked, ovr_set, wcol_set, any_flag;

  assign any_flag   = done || ovr || wcol;
  assign clr_evt    = data_rd && armed;
  assign wr_blocked = done && !armed;
  assign wr_ok      = data_wr && !wr_blocked && !busy;
  assign wcol_set   = data_wr && !wr_blocked && busy;
  assign ovr_set    = done_pulse && done && !clr_evt;
  assign irq        = done && irq_en && irq_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      ovr   <= 1'b0;
      wcol  <= 1'b0;
      armed <= 1'b0;
      rbuf  <= '0;
    end else begin
      if (done_pulse)   done <= 1'b1;
      else if (clr_evt) done <= 1'b0;
      if (ovr_set)      ovr <= 1'b1;
      else if (clr_evt) ovr <= 1'b0;
      if (wcol_set)     wcol <= 1'b1;
      else if (clr_evt) wcol <= 1'b0;
      if (clr_evt)                  armed <= 1'b0;
      else if (stat_rd && any_flag) armed <= 1'b1;
      if (done_pulse && !ovr_set) rbuf <= rx_next;
    end
  end

  // flag stays up until the two-step retire completes (R5)
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_evt) |=> done);

  p_fall_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(armed && data_rd));

  // overrun keeps the older byte (R7)
  p_ovr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> $stable(rbuf));

  // collision only from a write during a byte (R8)
  p_wcol_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(data_wr && busy));

  // no write reaches the shifter while blocked (R6)
  p_no_blocked_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !armed) |-> !wr_ok);
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         sck,
  input  logic         ss_n,
  input  logic         mosi,
  output logic         miso,
  output logic         irq
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] PIN_RST = 3'b010;

  // pin order: 0 data in, 1 select, 2 clock
  logic [NPIN-1:0] pin_raw, pin_s;
  assign pin_raw = {sck, ss_n, mosi};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    spi_tgt_sync #(.STAGES(STAGES), .RST_VAL(PIN_RST[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_raw[i]), .q(pin_s[i])
    );
  end

  logic sck_d, ss_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      ss_d  <= 1'b1;
    end else begin
      sck_d <= pin_s[2];
      ss_d  <= pin_s[1];
    end
  end

  logic sck_rise, sck_fall, ss_start, ss_act;
  assign sck_rise = pin_s[2] && !sck_d;
  assign sck_fall = !pin_s[2] && sck_d;
  assign ss_start = !pin_s[1] && ss_d;
  assign ss_act   = !pin_s[1];

  ctrl_t ctrl_q;
  logic data_wr, data_rd, stat_rd, ctrl_wr;
  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
  assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  logic         busy, done_pulse, wr_ok, done, ovr, wcol, armed;
  logic [W-1:0] rx_next, rbuf;

  spi_tgt_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .ss_start(ss_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(pin_s[0]),
    .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
    .load_en(wr_ok), .load_data(bus_wdata),
    .miso(miso), .busy(busy), .done_pulse(done_pulse), .rx_next(rx_next)
  );

  spi_tgt_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .rx_next(rx_next),
    .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr), .busy(busy),
    .irq_en(ctrl_q.irq_en), .irq_sel(ctrl_q.irq_sel),
    .done(done), .ovr(ovr), .wcol(wcol), .armed(armed), .wr_ok(wr_ok),
    .rbuf(rbuf), .irq(irq)
  );

  function automatic logic [W-1:0] read_mux(input logic [1:0] a, input logic [W-1:0] buf_v,
                                             input logic [2:0] flags, input ctrl_t c);
    case (a)
      ADDR_DATA: return buf_v;
      ADDR_STAT: return W'(flags);
      ADDR_CTRL: return W'(c);
      default:   return '0;
    endcase
  endfunction

  assign bus_rdata = read_mux(bus_addr, rbuf, {wcol, ovr, done}, ctrl_q);

  // a completion never arrives from a deselected port (R9)
  p_done_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ss_act);
endmodule

// File: tb/test_spi_tgt.sv
module test_spi_tgt;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, irq;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_tgt i_spi_tgt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  // control byte, byte to send, byte the controller sends
  localparam logic [21:0] VECS [0:3] = '{
    {6'b001100, 8'hA5, 8'h3C},
    {6'b110101, 8'h96, 8'hC3},
    {6'b001010, 8'h5A, 8'h81},
    {6'b101111, 8'hF0, 8'h0F}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic xfer(input logic cpol, input logic cpha, input logic [7:0] mo,
                      input int nbits, output logic [7:0] mi);
    mi = '0;
    sck = cpol;
    tick(HALF);
    ss_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi = mo[7-i];
        tick(HALF);
        mi[7-i] = miso;
        sck = ~cpol;
        tick(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mo[7-i];
        tick(HALF);
        mi[7-i] = miso;
        sck = cpol;
        tick(HALF);
      end
    end
    tick(HALF);
    ss_n = 1'b1;
    tick(12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, mi;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R10 reset state
    bus_read(2'd1, r); chk("R10 status", r, 8'h00);
    bus_read(2'd0, r); chk("R10 data", r, 8'h00);
    bus_read(2'd2, r); chk("R10 control", r, 8'h00);
    chk("R10 miso/irq", {6'b0, miso, irq}, 8'h00);

    // vector table: all four modes, rate field set in two of them
    for (int v = 0; v < 4; v++) begin
      logic [5:0] c;
      logic [7:0] tx, mo;
      {c, tx, mo} = VECS[v];
      bus_write(2'd2, {2'b00, c});
      bus_read(2'd2, r); chk("R2 control readback", r, {2'b00, c});
      bus_write(2'd0, tx);
      xfer(c[0], c[1], mo, 8, mi);
      chk("R1 miso byte", mi, tx);
      chk("R4 irq after byte", {7'b0, irq}, {7'b0, c[3] & c[2]});
      bus_read(2'd0, r); chk("R3 buffered byte", r, mo);
      bus_read(2'd1, r); chk("R5 data read alone keeps flag", r, 8'h01);
      bus_read(2'd0, r); chk("R1 mosi byte", r, mo);
      bus_read(2'd1, r); chk("R5 flag retired", r, 8'h00);
      chk("R4 irq low after retire", {7'b0, irq}, 8'h00);
    end

    // R6 blocked write while flag is up and unread
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h11);
    xfer(1'b0, 1'b0, 8'h22, 8, mi);
    bus_write(2'd0, 8'hAA);
    bus_read(2'd1, r); chk("R6 flag set", r, 8'h01);
    bus_read(2'd0, r); chk("R6 buffer", r, 8'h22);
    xfer(1'b0, 1'b0, 8'h44, 8, mi);
    chk("R6 dropped write not sent", mi, 8'h00);
    // write after the status read is accepted
    bus_read(2'd1, r);
    bus_write(2'd0, 8'h3C);
    bus_read(2'd0, r); chk("R6 buffer second", r, 8'h44);
    xfer(1'b0, 1'b0, 8'h55, 8, mi);
    chk("R6 write after status read sent", mi, 8'h3C);

    // R7 overrun: leave the flag up across another byte
    xfer(1'b0, 1'b0, 8'h99, 8, mi);
    bus_read(2'd1, r); chk("R7 overrun flagged", r, 8'h03);
    bus_read(2'd0, r); chk("R7 older byte kept", r, 8'h55);
    bus_read(2'd1, r); chk("R7 flags retired", r, 8'h00);

    // R8 collision during a phase-0 byte
    bus_write(2'd0, 8'h80);
    @(negedge clk); ss_n = 1'b0;
    tick(8);
    chk("R8 msb out on select", {7'b0, miso}, 8'h01);
    bus_write(2'd0, 8'h55);
    tick(4);
    chk("R8 miso unchanged", {7'b0, miso}, 8'h01);
    bus_read(2'd1, r); chk("R8 collision flag", r, 8'h04);
    @(negedge clk); ss_n = 1'b1;
    tick(8);
    bus_read(2'd0, r);
    bus_read(2'd1, r); chk("R8 collision retired", r, 8'h00);

    // R9 abort, and R3 buffer unaffected by a live transfer
    xfer(1'b0, 1'b0, 8'hE7, 8, mi);
    bus_read(2'd1, r);
    bus_read(2'd0, r); chk("R9 setup byte", r, 8'hE7);
    xfer(1'b0, 1'b0, 8'h5B, 4, mi);
    bus_read(2'd0, r); chk("R3 buffer not live shift", r, 8'hE7);
    bus_read(2'd1, r); chk("R9 no completion on abort", r, 8'h00);
    xfer(1'b0, 1'b0, 8'h6D, 8, mi);
    bus_read(2'd1, r); chk("R9 next byte completes", r, 8'h01);
    bus_read(2'd0, r); chk("R9 next byte clean", r, 8'h6D);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule